// File: doc/BRIEF.md
# Rename History Buffer with Rollback

This block keeps, for one hardware thread, the ordered list of register renames that are still speculative. Every destination operand that the rename stage maps pushes one record at the young end. A record carries the instruction's sequence number, the architectural register, the physical register just allocated, and the physical register that held the mapping before. Instructions with no destination push nothing. A core with several threads instantiates one copy per thread.

Two walks drain the list, each from a different end. A retire command with limit C walks from the oldest end. It removes every record whose sequence number is at most C and returns that record's earlier physical register to the free list. An undo command with limit S walks from the youngest end. It removes every record whose sequence number exceeds S, writes the earlier physical register back into the map, and returns the new register to the free list. A flush command undoes every record in the same way. Each walk removes one record per cycle, and `busy` stays high while a walk is active.

The push side is a valid/ready stream: a record moves when `push_valid` and `push_ready` are both high in the same cycle. The sender must hold its record until that happens. The three write outputs (map restore, free-list return, scoreboard ready) are single-cycle valid strobes with no back-pressure. Their targets must accept a write in every cycle.

Top module: `rename_hist_buf`

## Requirements
- R1: A push is accepted only when `push_valid` and `push_ready` are both high. `push_ready` is low while the buffer holds DEPTH records, and `full` is then high. `push_ready` is also low throughout an undo or flush walk. A refused record is never stored.
- R2: After `cmd_squash` with limit S, the block removes records with sequence number greater than S, youngest first, one per cycle. The first removal happens in the cycle after the command. Each removal raises `map_wr_valid` with `map_wr_arch` set to the record's architectural register and `map_wr_phys` set to its earlier physical register. In the same cycle it raises `free_valid` with `free_phys` set to the record's new physical register.
- R3: During an undo or flush removal, `rdy_valid` is high with `rdy_phys` set to the new register exactly when that register index is at least NUM_INT_PHYS+NUM_FP_PHYS. It is never high during a retire.
- R4: After `cmd_commit` with limit C, the block removes records with sequence number at most C, oldest first, one per cycle. The first removal happens in the cycle after the command. Each removal raises `free_valid` with `free_phys` set to the earlier physical register, and `map_wr_valid` stays low.
- R5: A retire whose oldest record already has a sequence number above C makes no write. `busy` is high for one cycle and then falls.
- R6: `cmd_commit` is ignored when `cmd_squash` or `cmd_flush` is high in the same cycle, or when `squashing_in` is high. While `squashing_in` is high during a retire walk, no record is removed, and the walk resumes once it falls.
- R7: An undo or flush on an empty buffer makes no write, and `busy` falls after one cycle.
- R8: `cmd_flush` removes every record, youngest first, with the same outputs as R2 and R3.
- R9: `busy` rises in the cycle after an accepted command. It stays high through the last removal and one more cycle in which no write is made, then falls. Commands presented while `busy` is high are ignored.
- R10: After reset the buffer is empty, `busy` and `full` are low, `push_ready` is high, and no write strobe is high.
- R11: Pushes are accepted during a retire walk and land behind the records that are already stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | A record is offered |
| push_ready | output | 1 | The record is accepted this cycle |
| push_seq | input | SEQ_W | Sequence number of the renaming instruction |
| push_arch | input | ARCH_W | Architectural destination register |
| push_new | input | PHYS_W | Newly allocated physical register |
| push_prev | input | PHYS_W | Physical register previously mapped |
| cmd_commit | input | 1 | Start a retire walk |
| commit_seq | input | SEQ_W | Retire limit C (inclusive) |
| cmd_squash | input | 1 | Start an undo walk |
| squash_seq | input | SEQ_W | Undo limit S (records above it are undone) |
| cmd_flush | input | 1 | Undo every record |
| squashing_in | input | 1 | The thread is squashing; gates retirement |
| map_wr_valid | output | 1 | Map restore write strobe |
| map_wr_arch | output | ARCH_W | Map entry to restore |
| map_wr_phys | output | PHYS_W | Physical register written back into the map |
| free_valid | output | 1 | Free-list return strobe |
| free_phys | output | PHYS_W | Register returned to the free list |
| rdy_valid | output | 1 | Scoreboard set-ready strobe |
| rdy_phys | output | PHYS_W | Register marked ready |
| busy | output | 1 | A walk is active |
| full | output | 1 | Buffer holds DEPTH records |

## Verification
The bench sweeps every fill level from empty to full. For each level it sweeps every undo limit position, including limits below all records and above all of them. This separates a walk that stops at the right record from one that stops one record early or late, or that runs from the wrong end. A retire to an intermediate limit follows each undo. A flush after that shows exactly which records survived, which makes ignored commands, refused pushes and pushes during a retire visible at the outputs. Register indices produced by the bench cross the misc threshold, so the scoreboard strobe is exercised both high and low within a single walk.

// File: rtl/rhb_pkg.sv
package rhb_pkg;
  typedef enum logic [1:0] {
    WK_IDLE   = 2'd0,
    WK_RETIRE = 2'd1,
    WK_UNDO   = 2'd2,
    WK_FLUSH  = 2'd3
  } walk_e;
endpackage

// File: rtl/rhb_store.sv
module rhb_store #(
  parameter int DEPTH  = 8,
  parameter int SEQ_W  = 16,
  parameter int ARCH_W = 5,
  parameter int PHYS_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_en,
  input  logic [SEQ_W-1:0]  in_seq,
  input  logic [ARCH_W-1:0] in_arch,
  input  logic [PHYS_W-1:0] in_new,
  input  logic [PHYS_W-1:0] in_prev,
  input  logic              pop_old,
  input  logic              pop_young,
  output logic [SEQ_W-1:0]  old_seq,
  output logic [PHYS_W-1:0] old_prev,
  output logic [SEQ_W-1:0]  young_seq,
  output logic [ARCH_W-1:0] young_arch,
  output logic [PHYS_W-1:0] young_new,
  output logic [PHYS_W-1:0] young_prev,
  output logic              empty,
  output logic              full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [SEQ_W-1:0]  seq_m  [DEPTH];
  logic [ARCH_W-1:0] arch_m [DEPTH];
  logic [PHYS_W-1:0] new_m  [DEPTH];
  logic [PHYS_W-1:0] prev_m [DEPTH];

  logic [PTR_W-1:0] head_q, tail_q, young_idx;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PTR_W-1:0] ptr_dec(input logic [PTR_W-1:0] p);
    return (p == '0) ? LAST : p - 1'b1;
  endfunction

  assign young_idx  = ptr_dec(tail_q);
  assign empty      = (cnt_q == '0);
  assign full       = (cnt_q == CNT_W'(DEPTH));
  assign old_seq    = seq_m[head_q];
  assign old_prev   = prev_m[head_q];
  assign young_seq  = seq_m[young_idx];
  assign young_arch = arch_m[young_idx];
  assign young_new  = new_m[young_idx];
  assign young_prev = prev_m[young_idx];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push_en && tail_q == PTR_W'(g)) begin
        seq_m[g]  <= in_seq;
        arch_m[g] <= in_arch;
        new_m[g]  <= in_new;
        prev_m[g] <= in_prev;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (pop_old)   head_q <= ptr_inc(head_q);
      if (pop_young) tail_q <= ptr_dec(tail_q);
      else if (push_en) tail_q <= ptr_inc(tail_q);
      cnt_q <= cnt_q + CNT_W'(push_en) - CNT_W'(pop_old | pop_young);
    end
  end

  p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  p_no_push_full_r1: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push_en);
  p_no_push_undo_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pop_young |-> !push_en);
  p_pop_nonempty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_old || pop_young) |-> !empty);
  p_grow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (push_en && !pop_old && !pop_young) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/rhb_walker.sv
module rhb_walker
  import rhb_pkg::*;
#(
  parameter int SEQ_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_commit,
  input  logic [SEQ_W-1:0] commit_seq,
  input  logic             cmd_squash,
  input  logic [SEQ_W-1:0] squash_seq,
  input  logic             cmd_flush,
  input  logic             squashing_in,
  input  logic             empty,
  input  logic [SEQ_W-1:0] old_seq,
  input  logic [SEQ_W-1:0] young_seq,
  output logic             pop_old,
  output logic             pop_young,
  output logic             undo_active,
  output logic             busy
);
  walk_e            state_q;
  logic [SEQ_W-1:0] lim_q;

  always_comb begin
    pop_old   = (state_q == WK_RETIRE) && !squashing_in && !empty && (old_seq <= lim_q);
    pop_young = ((state_q == WK_UNDO) && !empty && (young_seq > lim_q)) ||
                ((state_q == WK_FLUSH) && !empty);
  end

  assign undo_active = (state_q == WK_UNDO) || (state_q == WK_FLUSH);
  assign busy        = (state_q != WK_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= WK_IDLE;
      lim_q   <= '0;
    end else begin
      unique case (state_q)
        WK_IDLE: begin
          if (cmd_flush) begin
            state_q <= WK_FLUSH;
          end else if (cmd_squash) begin
            state_q <= WK_UNDO;
            lim_q   <= squash_seq;
          end else if (cmd_commit && !squashing_in) begin
            state_q <= WK_RETIRE;
            lim_q   <= commit_seq;
          end
        end
        WK_RETIRE: if (!squashing_in && !pop_old) state_q <= WK_IDLE;
        WK_UNDO, WK_FLUSH: if (!pop_young) state_q <= WK_IDLE;
        default: state_q <= WK_IDLE;
      endcase
    end
  end

  p_commit_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WK_IDLE && cmd_commit && (cmd_squash || cmd_flush || squashing_in))
      |=> state_q != WK_RETIRE);
  p_retire_pause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WK_RETIRE && squashing_in) |=> state_q == WK_RETIRE);
  p_empty_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (undo_active && empty) |=> state_q == WK_IDLE);
  p_busy_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_old || pop_young) |=> busy);
endmodule

// File: rtl/rename_hist_buf.sv
module rename_hist_buf #(
  parameter int DEPTH        = 8,
  parameter int SEQ_W        = 16,
  parameter int ARCH_W       = 5,
  parameter int PHYS_W       = 7,
  parameter int NUM_INT_PHYS = 48,
  parameter int NUM_FP_PHYS  = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  output logic              push_ready,
  input  logic [SEQ_W-1:0]  push_seq,
  input  logic [ARCH_W-1:0] push_arch,
  input  logic [PHYS_W-1:0] push_new,
  input  logic [PHYS_W-1:0] push_prev,
  input  logic              cmd_commit,
  input  logic [SEQ_W-1:0]  commit_seq,
  input  logic              cmd_squash,
  input  logic [SEQ_W-1:0]  squash_seq,
  input  logic              cmd_flush,
  input  logic              squashing_in,
  output logic              map_wr_valid,
  output logic [ARCH_W-1:0] map_wr_arch,
  output logic [PHYS_W-1:0] map_wr_phys,
  output logic              free_valid,
  output logic [PHYS_W-1:0] free_phys,
  output logic              rdy_valid,
  output logic [PHYS_W-1:0] rdy_phys,
  output logic              busy,
  output logic              full
);
  localparam int MISC_BASE = NUM_INT_PHYS + NUM_FP_PHYS;
  localparam logic [PHYS_W:0] MISC_BASE_V = (PHYS_W + 1)'(MISC_BASE);

  logic              push_en, pop_old, pop_young, empty, undo_active;
  logic [SEQ_W-1:0]  old_seq, young_seq;
  logic [PHYS_W-1:0] old_prev, young_new, young_prev;
  logic [ARCH_W-1:0] young_arch;
  logic              young_is_misc;

  assign push_ready = !full && !undo_active;
  assign push_en    = push_valid && push_ready;

  rhb_store #(
    .DEPTH(DEPTH), .SEQ_W(SEQ_W), .ARCH_W(ARCH_W), .PHYS_W(PHYS_W)
  ) store_i (
    .clk(clk), .rst_n(rst_n), .push_en(push_en),
    .in_seq(push_seq), .in_arch(push_arch), .in_new(push_new), .in_prev(push_prev),
    .pop_old(pop_old), .pop_young(pop_young),
    .old_seq(old_seq), .old_prev(old_prev),
    .young_seq(young_seq), .young_arch(young_arch),
    .young_new(young_new), .young_prev(young_prev),
    .empty(empty), .full(full)
  );

  rhb_walker #(.SEQ_W(SEQ_W)) walker_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_commit(cmd_commit), .commit_seq(commit_seq),
    .cmd_squash(cmd_squash), .squash_seq(squash_seq),
    .cmd_flush(cmd_flush), .squashing_in(squashing_in),
    .empty(empty), .old_seq(old_seq), .young_seq(young_seq),
    .pop_old(pop_old), .pop_young(pop_young),
    .undo_active(undo_active), .busy(busy)
  );

  assign young_is_misc = ({1'b0, young_new} >= MISC_BASE_V);

  assign map_wr_valid = pop_young;
  assign map_wr_arch  = young_arch;
  assign map_wr_phys  = young_prev;
  assign free_valid   = pop_young || pop_old;
  assign free_phys    = pop_young ? young_new : old_prev;
  assign rdy_valid    = pop_young && young_is_misc;
  assign rdy_phys     = young_new;

  p_rdy_in_undo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_valid |-> (map_wr_valid && free_phys == rdy_phys));
  p_retire_no_map_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (free_valid && !map_wr_valid) |-> !rdy_valid);
endmodule

// File: tb/rename_hist_buf_tb_top.sv
`timescale 1ns/1ps
module rename_hist_buf_tb_top;
  localparam int DEPTH = 8;
  localparam int MISC = 96;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        push_valid = 0, push_ready;
  logic [15:0] push_seq = '0;
  logic [4:0]  push_arch = '0;
  logic [6:0]  push_new = '0, push_prev = '0;
  logic        cmd_commit = 0, cmd_squash = 0, cmd_flush = 0, squashing_in = 0;
  logic [15:0] commit_seq = '0, squash_seq = '0;
  logic        map_wr_valid, free_valid, rdy_valid, busy, full;
  logic [4:0]  map_wr_arch;
  logic [6:0]  map_wr_phys, free_phys, rdy_phys;

  rename_hist_buf #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_ready(push_ready),
    .push_seq(push_seq), .push_arch(push_arch), .push_new(push_new), .push_prev(push_prev),
    .cmd_commit(cmd_commit), .commit_seq(commit_seq), .cmd_squash(cmd_squash),
    .squash_seq(squash_seq), .cmd_flush(cmd_flush), .squashing_in(squashing_in),
    .map_wr_valid(map_wr_valid), .map_wr_arch(map_wr_arch), .map_wr_phys(map_wr_phys),
    .free_valid(free_valid), .free_phys(free_phys), .rdy_valid(rdy_valid),
    .rdy_phys(rdy_phys), .busy(busy), .full(full)
  );

  int total = 0, bad = 0;
  int gseq = 10;
  int ms [DEPTH+2];
  int ma [DEPTH+2];
  int mn [DEPTH+2];
  int mp [DEPTH+2];
  int mcnt = 0;

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
    end
  endtask

  function automatic int gen_new(input int s); return (s * 7 + 3) % 128; endfunction
  function automatic int gen_prev(input int s); return (s * 5 + 1) % 128; endfunction

  task automatic model_push();
    ms[mcnt] = gseq; ma[mcnt] = gseq % 32; mn[mcnt] = gen_new(gseq); mp[mcnt] = gen_prev(gseq);
    mcnt++;
  endtask

  task automatic drive_rec();
    push_seq = 16'(gseq); push_arch = 5'(gseq % 32);
    push_new = 7'(gen_new(gseq)); push_prev = 7'(gen_prev(gseq));
  endtask

  // R1: offer one record; it is accepted only while fewer than DEPTH are held
  task automatic push_one();
    bit exp_ok;
    @(negedge clk);
    drive_rec();
    push_valid = 1'b1;
    #1;
    exp_ok = (mcnt < DEPTH);
    check(push_ready == exp_ok, "R1 push_ready", int'(push_ready), int'(exp_ok));
    check(full == !exp_ok, "R1 full", int'(full), int'(!exp_ok));
    @(posedge clk); #1;
    push_valid = 1'b0;
    if (exp_ok) model_push();
    gseq += 2;
  endtask

  // mode: 0 retire, 1 undo, 2 flush
  task automatic issue(input int mode, input int lim);
    @(negedge clk);
    if (mode == 0) begin cmd_commit = 1; commit_seq = 16'(lim); end
    if (mode == 1) begin cmd_squash = 1; squash_seq = 16'(lim); end
    if (mode == 2) cmd_flush = 1;
    @(posedge clk); #1;
    cmd_commit = 0; cmd_squash = 0; cmd_flush = 0;
  endtask

  task automatic drain(input int mode, input int lim, input int pause,
                       input bit inj_commit, input bit inj_push);
    bit done = 0, first = 1, exp_pop, pushed;
    int p = pause;
    string tg;
    tg = (mode == 0) ? "R4" : ((mode == 1) ? "R2" : "R8");
    while (!done) begin
      pushed = 0;
      @(negedge clk);
      squashing_in = (p > 0);
      if (inj_commit && first) begin cmd_commit = 1; commit_seq = 16'hFFF0; end
      if (inj_push && first) begin drive_rec(); push_valid = 1; end
      #1;
      if (inj_push && first) begin
        check(push_ready == 1'b1, "R11 push during retire", int'(push_ready), 1);
        pushed = 1;
      end
      if (mode != 0) check(push_ready == 1'b0, "R1 ready low in undo", int'(push_ready), 0);
      if (p > 0) begin
        check(free_valid == 1'b0 && busy == 1'b1, "R6 paused retire",
              int'({busy, free_valid}), 2);
        p--;
      end else begin
        if (mode == 0) exp_pop = (mcnt > 0) && (ms[0] <= lim);
        else if (mode == 1) exp_pop = (mcnt > 0) && (ms[mcnt-1] > lim);
        else exp_pop = (mcnt > 0);
        if (exp_pop && mode == 0) begin
          check(free_valid == 1'b1, "R4 free_valid", int'(free_valid), 1);
          check(int'(free_phys) == mp[0], "R4 free_phys prev", int'(free_phys), mp[0]);
          check(map_wr_valid == 1'b0 && rdy_valid == 1'b0, "R4 no map/rdy",
                int'({map_wr_valid, rdy_valid}), 0);
          for (int i = 0; i < mcnt - 1; i++) begin
            ms[i] = ms[i+1]; ma[i] = ma[i+1]; mn[i] = mn[i+1]; mp[i] = mp[i+1];
          end
          mcnt--;
        end else if (exp_pop) begin
          check(map_wr_valid == 1'b1 && free_valid == 1'b1, {tg, " strobes"},
                int'({map_wr_valid, free_valid}), 3);
          check(int'(map_wr_arch) == ma[mcnt-1], {tg, " map arch"}, int'(map_wr_arch), ma[mcnt-1]);
          check(int'(map_wr_phys) == mp[mcnt-1], {tg, " map prev"}, int'(map_wr_phys), mp[mcnt-1]);
          check(int'(free_phys) == mn[mcnt-1], {tg, " free new"}, int'(free_phys), mn[mcnt-1]);
          check(rdy_valid == (mn[mcnt-1] >= MISC), "R3 rdy_valid", int'(rdy_valid),
                int'(mn[mcnt-1] >= MISC));
          if (rdy_valid) check(int'(rdy_phys) == mn[mcnt-1], "R3 rdy_phys", int'(rdy_phys), mn[mcnt-1]);
          mcnt--;
        end else begin
          check(!map_wr_valid && !free_valid && !rdy_valid && busy,
                "R9 final idle-write cycle", int'({busy, map_wr_valid, free_valid, rdy_valid}), 8);
          done = 1;
        end
      end
      if (pushed) begin model_push(); gseq += 2; end
      first = 0;
      @(posedge clk); #1;
      cmd_commit = 0; push_valid = 0;
    end
    squashing_in = 0;
    @(negedge clk); #1;
    check(busy == 1'b0, "R9 busy falls", int'(busy), 0);
  endtask

  task automatic flush_all();
    issue(2, 0);
    drain(2, 0, 0, 0, 0);
    check(mcnt == 0, "R8 model empty", mcnt, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    // R10 reset state
    check(push_ready && !busy && !full, "R10 reset flags", int'({push_ready, busy, full}), 4);
    check(!map_wr_valid && !free_valid && !rdy_valid, "R10 no strobes",
          int'({map_wr_valid, free_valid, rdy_valid}), 0);

    // sweep fill level n and undo limit position k, then a partial retire
    for (int n = 0; n <= DEPTH; n++) begin
      for (int k = 0; k <= n; k++) begin
        flush_all();
        base = gseq;
        for (int i = 0; i < n; i++) push_one();
        if (n == DEPTH) push_one(); // R1 refused push when full
        issue(1, base + 2 * k - 1);  // R2 (and R7 when n == 0)
        drain(1, base + 2 * k - 1, 0, (k == 1), 0);
        issue(0, base + 2 * (k / 2)); // R4
        drain(0, base + 2 * (k / 2), 0, 0, 0);
      end
    end

    // R5: retire limit below oldest
    flush_all();
    base = gseq;
    push_one(); push_one();
    issue(0, base - 1);
    drain(0, base - 1, 0, 0, 0);
    check(mcnt == 2, "R5 nothing retired", mcnt, 2);

    // R6: commit with squash in same cycle -> only the undo acts
    @(negedge clk);
    cmd_commit = 1; commit_seq = 16'hFFF0; cmd_squash = 1; squash_seq = 16'(base);
    @(posedge clk); #1;
    cmd_commit = 0; cmd_squash = 0;
    drain(1, base, 0, 0, 0);

    // R6: commit while squashing_in is ignored
    @(negedge clk);
    cmd_commit = 1; commit_seq = 16'hFFF0; squashing_in = 1;
    @(posedge clk); #1;
    cmd_commit = 0; squashing_in = 0;
    @(negedge clk); #1;
    check(!busy && !free_valid, "R6 commit ignored while squashing",
          int'({busy, free_valid}), 0);

    // R6 pause mid-retire, R11 push during retire
    push_one(); push_one();
    issue(0, gseq - 3);
    drain(0, gseq - 3, 2, 0, 1);
    issue(0, 16'hFFF0);
    drain(0, 16'hFFF0, 0, 0, 1);
    flush_all();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule